// File: doc/BRIEF.md
# Lane-Partitioned Priority Select

This unit evaluates an ordered if / else-if / else chain over a 32-bit datapath that a run-time mask can split into four 8-bit lanes. Every branch brings a condition word with one test bit per lane and a full-width data candidate. Each lane group decides on its own which branch wins, using first-match priority. It then drives its slice of the result from the same slice of the winning candidate. A group in which no branch matches takes its slice from the default input, which acts as the else branch.

A 3-bit mask sets the grouping. Mask bit i places a boundary between lane i and lane i+1. When that bit is clear, the two lanes merge into one wider group. One structure covers the whole-width case, the two-way and four-way splits, and every uneven split in between. The unit is purely combinational. Condition generation, such as partitioned compares, is done by its neighbours.

Top module: `psel_top`

## Requirements
- R1: Lane k occupies result bits [8k+7:8k]. Mask bit i set places a group boundary between lane i and lane i+1. Mask bit i clear merges those two lanes into one group.
- R2: Branch b's test bit for lane k is cond_i bit b*4+k. Each group outputs, on its lanes, the same lanes of the candidate data_i[b*32 +: 32] for the lowest-numbered branch b whose test bit is set.
- R3: When several branches have their test bit set in a group, branch 0 beats branch 1, and so on. The data of the losing branches has no effect on that group's output.
- R4: When no branch's test bit is set for a group, that group's result lanes equal the same lanes of dflt_i.
- R5: Within a merged group, only the test bits of the group's least-significant lane decide the choice. Test bits of the other lanes in the group are ignored, and the whole group takes one branch.
- R6: Groups decide independently. A group's result lanes never take bits from another lane's slice of any candidate or of the default.
- R7: All eight mask values work with the same logic: 3'b000 is one 32-bit group, 3'b111 gives four 8-bit groups, 3'b010 gives two 16-bit groups, and the uneven splits are supported as well.
- R8: The result follows the inputs without any clock edge; there is no stored state.
- R9: The branch count is a parameter of at least two. With the default of three, the third branch is reachable when only its test bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mask_i | input | 3 | Group boundary mask, bit i between lane i and lane i+1 |
| cond_i | input | 12 | Test bits, branch b lane k at bit b*4+k |
| data_i | input | 96 | Branch candidates, branch b at bits [b*32 +: 32] |
| dflt_i | input | 32 | Else-branch value |
| res_o | output | 32 | Selected result |

## Verification
The assertions assume only that every input is a known 0/1 value by the time the combinational logic settles. They make no assumption about which condition patterns are legal: any number of test bits may be set in any lane, including lanes whose bits are ignored because of merging. The stimulus drives only fully known values and changes inputs away from the sampling point. Random condition words sweep all eight masks, and directed cases set test bits only in non-leading lanes so that a wrong leader choice becomes visible at the result.

// File: rtl/psel_pkg.sv
// Package: shared sizes for the partitioned priority select.
// Assumes the lane count is a power of two and at least two.
package psel_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned DATA_W = LANES * LANE_W;
    localparam int unsigned MASK_W = LANES - 1;
    localparam int unsigned IDX_W  = $clog2(LANES);
endpackage

// File: rtl/psel_group_lead.sv
// Module: finds, for each lane, the least-significant lane of its group.
// Assumes mask bit i marks a boundary between lane i and lane i+1.
module psel_group_lead
    import psel_pkg::*;
(
    input  logic [MASK_W-1:0]            mask_i,
    output logic [LANES-1:0][IDX_W-1:0]  lead_o
);
    assign lead_o[0] = '0;

    genvar k;
    generate
        for (k = 1; k < LANES; k++) begin : g_lead
            // Start a new group at a boundary, else inherit the lower lane's leader.
            assign lead_o[k] = mask_i[k-1] ? IDX_W'(k) : lead_o[k-1];

            // R1
            always_comb begin
                lead_not_above_chk: assert (lead_o[k] <= IDX_W'(k));
            end
        end
    endgenerate
endmodule

// File: rtl/psel_lane_pick.sv
// Module: first-match priority encoder for one lane's test vector.
// Assumes bit 0 is the highest-priority branch; outputs a one-hot choice or none.
module psel_lane_pick #(
    parameter int unsigned NUM_BR = 3
) (
    input  logic [NUM_BR-1:0] tests_i,
    output logic [NUM_BR-1:0] sel_o,
    output logic              none_o
);
    // Scan branches in order and keep only the first set test bit.
    always_comb begin
        logic hit;
        hit   = 1'b0;
        sel_o = '0;
        for (int b = 0; b < NUM_BR; b++) begin
            if (tests_i[b] && !hit) begin
                sel_o[b] = 1'b1;
                hit      = 1'b1;
            end
        end
        none_o = !hit;
    end

    // Guard the encoder outputs against its inputs.
    always_comb begin
        // R3
        single_pick_chk: assert ($onehot0(sel_o));
        // R3
        first_wins_chk: assert (!tests_i[0] || sel_o[0]);
        // R4
        none_empty_chk: assert (!none_o || (tests_i == '0));
    end
endmodule

// File: rtl/psel_lane_mux.sv
// Module: drives one lane slice from the chosen candidate or the default.
// Assumes sel_i is one-hot or zero, and none_i is set only when sel_i is zero.
module psel_lane_mux #(
    parameter int unsigned NUM_BR = 3,
    parameter int unsigned LANE_W = 8
) (
    input  logic [NUM_BR*LANE_W-1:0] cand_i,
    input  logic [LANE_W-1:0]        dflt_i,
    input  logic [NUM_BR-1:0]        sel_i,
    input  logic                     none_i,
    output logic [LANE_W-1:0]        out_o
);
    // AND-OR the candidates with the choice, then add the default term.
    always_comb begin
        out_o = none_i ? dflt_i : '0;
        for (int b = 0; b < NUM_BR; b++) begin
            out_o = out_o | (cand_i[b*LANE_W +: LANE_W] & {LANE_W{sel_i[b]}});
        end
    end
endmodule

// File: rtl/psel_top.sv
// Module: lane-partitioned if/else-if/else select over a 32-bit datapath.
// Assumes NUM_BR >= 2; purely combinational, with no clock or reset.
module psel_top
    import psel_pkg::*;
#(
    parameter int unsigned NUM_BR = 3
) (
    input  logic [MASK_W-1:0]        mask_i,
    input  logic [NUM_BR*LANES-1:0]  cond_i,
    input  logic [NUM_BR*DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0]        dflt_i,
    output logic [DATA_W-1:0]        res_o
);
    logic [LANES-1:0][IDX_W-1:0]  lead;
    logic [LANES-1:0][NUM_BR-1:0] tests;
    logic [LANES-1:0][NUM_BR-1:0] sel;
    logic [LANES-1:0]             none;

    psel_group_lead i_lead (
        .mask_i (mask_i),
        .lead_o (lead)
    );

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            logic [NUM_BR*LANE_W-1:0] cand;

            // Gather the leader lane's test bit from every branch.
            always_comb begin
                for (int b = 0; b < NUM_BR; b++) begin
                    tests[k][b] = cond_i[b*LANES + int'(lead[k])];
                end
            end

            // Slice lane k out of every candidate.
            always_comb begin
                for (int b = 0; b < NUM_BR; b++) begin
                    cand[b*LANE_W +: LANE_W] = data_i[b*DATA_W + k*LANE_W +: LANE_W];
                end
            end

            psel_lane_pick #(.NUM_BR(NUM_BR)) i_pick (
                .tests_i (tests[k]),
                .sel_o   (sel[k]),
                .none_o  (none[k])
            );

            psel_lane_mux #(.NUM_BR(NUM_BR), .LANE_W(LANE_W)) i_mux (
                .cand_i (cand),
                .dflt_i (dflt_i[k*LANE_W +: LANE_W]),
                .sel_i  (sel[k]),
                .none_i (none[k]),
                .out_o  (res_o[k*LANE_W +: LANE_W])
            );

            if (k > 0) begin : g_merge_chk
                // Merged neighbours must agree on one branch.
                always_comb begin
                    // R5
                    group_same_pick_chk: assert (mask_i[k-1] || (sel[k] == sel[k-1] && none[k] == none[k-1]));
                end
            end

            // A lane in its own group with branch 0 set must show branch 0's slice.
            always_comb begin
                // R6
                own_lane_data_chk: assert (!((k == 0 || mask_i[k-1]) && cond_i[k])
                                           || res_o[k*LANE_W +: LANE_W] == data_i[k*LANE_W +: LANE_W]);
            end
        end
    endgenerate
endmodule

// File: tb/test_psel_top.sv
module test_psel_top;
    localparam int NB = 3;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]       mask;
    logic [NB*4-1:0]  cond;
    logic [NB*DW-1:0] data;
    logic [DW-1:0]    dflt;
    logic [DW-1:0]    res;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psel_top #(.NUM_BR(NB)) i_psel_top (
        .mask_i (mask), .cond_i (cond), .data_i (data), .dflt_i (dflt), .res_o (res)
    );

    function automatic logic [DW-1:0] ref_model(input logic [2:0] m, input logic [NB*4-1:0] c,
                                                input logic [NB*DW-1:0] d, input logic [DW-1:0] e);
        logic [DW-1:0] r;
        r = e;
        for (int k = 0; k < 4; k++) begin
            int ld;
            ld = k;
            while (ld > 0 && !m[ld-1]) ld--;
            for (int b = NB - 1; b >= 0; b--) begin
                if (c[b*4 + ld]) r[k*8 +: 8] = d[b*DW + k*8 +: 8];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] exp);
        #1;
        total++;
        if (res !== exp) begin
            bad++;
            $display("FAIL %s mask=%b cond=%h act=%h exp=%h", tag, mask, cond, res, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [NB*4-1:0] c);
        mask = m; cond = c;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        data = {32'hCCCC_CCCC, 32'hBBBB_BBBB, 32'hAAAA_AAAA};
        dflt = 32'h1111_1111;
        apply(3'b111, '0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: nothing set, default everywhere
        check("R4", 32'h1111_1111);
        data = {32'hC3C2_C1C0, 32'hB3B2_B1B0, 32'hA3A2_A1A0};
        dflt = 32'hD3D2_D1D0;
        // R2 R1 R6: four lanes, branch 0 in lane 0, branch 1 in lane 2
        apply(3'b111, 12'b0000_0100_0001);
        check("R2", 32'hD3B2_D1A0);
        // R3: all branches set in lane 3, branch 0 wins
        apply(3'b111, 12'b1000_1000_1000);
        check("R3", 32'hA3D2_D1D0);
        // R9: only the third branch set in lane 1
        apply(3'b111, 12'b0010_0000_0000);
        check("R9", 32'hD3D2_C1D0);
        // R5: whole width, test bits only in lanes 1-3 are ignored
        apply(3'b000, 12'b1110_1110_1110);
        check("R5", 32'hD3D2_D1D0);
        // R5 R7: whole width, lane 0 selects branch 1 for all lanes
        apply(3'b000, 12'b0000_0001_0000);
        check("R7", 32'hB3B2_B1B0);
        // R1 R7: two halves; upper leader lane 2
        apply(3'b010, 12'b0100_1000_0001);
        check("R1", 32'hC3C2_A1A0);
        // R7: uneven split 1 + 3 lanes
        apply(3'b001, 12'b0000_0010_0000);
        check("R7", 32'hB3B2_B1D0);
        // R8: change data mid-cycle, no clock edge in between
        #2 data[DW-1:0] = 32'h5555_5555;
        apply(3'b111, 12'b0000_0000_1111);
        check("R8", 32'h5555_5555);
        @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            mask = 3'(i % 8);
            cond = NB*4'($urandom);
            data = {$urandom, $urandom, $urandom};
            dflt = $urandom;
            if (i % 5 == 0) cond = '0;
            check("R7", ref_model(mask, cond, data, dflt));
            @(negedge clk);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule